// File: doc/BRIEF.md
# Streaming Symbol Width Downconverter

This block sits between a wide packet stream and a narrower consumer, such as a DMA write path. The wide stream carries three 64-bit symbols in each 192-bit beat. The narrow stream carries one 64-bit symbol per beat. Both streams use a valid/ready handshake with start-of-packet and end-of-packet markers. Each wide beat is accepted into a holding register. It then leaves as up to three consecutive narrow beats, the most significant symbol first. Backpressure from the narrow side stalls the wide side.

The conversion follows packet boundaries. On the final wide beat of a packet, the input empty count gives how many trailing symbols carry no data. Those symbols are dropped. End-of-packet is moved onto the last symbol actually sent, and start-of-packet is kept only on the first narrow beat of a wide beat. Both sides run on one clock, with a synchronous active-high reset.

Top module: `sym_narrow`

## Requirements
- R1: Each accepted wide beat is emitted in this order: bits 191:128 first, then bits 127:64, then bits 63:0, each as one narrow beat.
- R2: A beat moves on either side only in a cycle where that side's valid and ready are both high. While input valid is low, nothing is loaded.
- R3: Start-of-packet on a wide beat appears only on the first narrow beat made from it.
- R4: On a wide beat with end-of-packet set and empty E (0, 1 or 2), exactly 3−E symbols are sent. End-of-packet is raised on the last of them and on no other narrow beat.
- R5: When end-of-packet is low, the input empty value has no effect and all three symbols are sent.
- R6: An input empty value of 3 with end-of-packet set is handled as 2, so one symbol is sent.
- R7: Input ready is high when the holding register is empty, or when its last symbol is taken downstream in the same cycle. A packet then streams with no idle output cycle while the output is always ready.
- R8: While output valid is high and output ready is low, output valid, data and both markers hold their values.
- R9: Reset clears the holding register, so that output valid goes low and input ready goes high.
- R10: The output empty signal is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both streams |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Wide beat offered |
| in_ready | output | 1 | Wide beat can be taken this cycle |
| in_data | input | 192 | Three symbols; the most significant symbol goes out first |
| in_sop | input | 1 | Wide beat starts a packet |
| in_eop | input | 1 | Wide beat ends a packet |
| in_empty | input | 2 | Unused trailing symbols; read only with in_eop |
| out_valid | output | 1 | Narrow beat offered |
| out_ready | input | 1 | Consumer takes the narrow beat |
| out_data | output | 64 | One symbol |
| out_sop | output | 1 | Narrow beat starts a packet |
| out_eop | output | 1 | Narrow beat ends a packet |
| out_empty | output | 1 | Always zero |

## Verification
A wide beat accepted at a rising edge shows its first symbol on the output in the cycle right after that edge. Each later symbol moves up one cycle after each edge at which the output is taken. Input ready follows the holding state within the same cycle, with no register in between. The bench drives inputs on the falling edge and reads every port one time unit before the next rising edge. A monitor records each narrow transfer together with its cycle number, so the checks can compare both the order of the symbols and how close together they arrive.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // Number of symbols that carry data in a wide beat; empty beyond the
  // symbol count is clamped so at least one symbol always leaves.
  function automatic int unsigned kept_syms(input int unsigned syms,
                                            input int unsigned empty,
                                            input bit          eop);
    int unsigned e;
    if (!eop) return syms;
    e = (empty > syms - 1) ? syms - 1 : empty;
    return syms - e;
  endfunction

endpackage

// File: rtl/sdc_hold.sv
module sdc_hold #(
  parameter int SYM_W   = 64,
  parameter int IN_SYMS = 3,
  parameter int IDX_W   = 2,
  parameter int EMP_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     advance,
  input  logic [SYM_W*IN_SYMS-1:0] in_data,
  input  logic                     in_sop,
  input  logic                     in_eop,
  input  logic [EMP_W-1:0]         in_empty,
  output logic                     full,
  output logic [IDX_W-1:0]         idx,
  output logic                     last,
  output logic [SYM_W*IN_SYMS-1:0] hold_data,
  output logic                     hold_sop,
  output logic                     hold_eop
);
  import sdc_pkg::*;

  localparam int CNT_W = $clog2(IN_SYMS + 1);

  logic [CNT_W-1:0] cnt;

  assign last = ((CNT_W'(idx) + CNT_W'(1)) == cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      hold_sop <= 1'b0;
      hold_eop <= 1'b0;
    end else if (load) begin
      hold_data <= in_data;
      hold_sop  <= in_sop;
      hold_eop  <= in_eop;
      cnt       <= CNT_W'(kept_syms(IN_SYMS, int'(in_empty), in_eop));
      idx       <= '0;
      full      <= 1'b1;
    end else if (advance) begin
      if (last) full <= 1'b0;
      else      idx  <= idx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/sdc_pick.sv
module sdc_pick #(
  parameter int SYM_W   = 64,
  parameter int IN_SYMS = 3,
  parameter int IDX_W   = 2
) (
  input  logic [SYM_W*IN_SYMS-1:0] hold_data,
  input  logic                     hold_sop,
  input  logic                     hold_eop,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     last,
  output logic [SYM_W-1:0]         sym,
  output logic                     sym_sop,
  output logic                     sym_eop
);
  logic [SYM_W-1:0] lane [IN_SYMS];

  // lane 0 is the most significant symbol, sent first
  for (genvar g = 0; g < IN_SYMS; g++) begin : g_lane
    assign lane[g] = hold_data[(IN_SYMS-1-g)*SYM_W +: SYM_W];
  end

  always_comb begin
    sym = '0;
    for (int i = 0; i < IN_SYMS; i++) begin
      if (IDX_W'(i) == idx) sym = lane[i];
    end
  end

  assign sym_sop = hold_sop && (idx == '0);
  assign sym_eop = hold_eop && last;

endmodule

// File: rtl/sym_narrow.sv
module sym_narrow #(
  parameter int SYM_W   = 64,
  parameter int IN_SYMS = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [SYM_W*IN_SYMS-1:0]     in_data,
  input  logic                         in_sop,
  input  logic                         in_eop,
  input  logic [$clog2(IN_SYMS)-1:0]   in_empty,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [SYM_W-1:0]             out_data,
  output logic                         out_sop,
  output logic                         out_eop,
  output logic [0:0]                   out_empty
);
  localparam int EMP_W = $clog2(IN_SYMS);
  localparam int IDX_W = $clog2(IN_SYMS);

  logic                     full, last, load, advance;
  logic [IDX_W-1:0]         idx;
  logic [SYM_W*IN_SYMS-1:0] hold_data;
  logic                     hold_sop, hold_eop;

  assign advance  = full && out_ready;
  assign in_ready = !full || (out_ready && last);
  assign load     = in_valid && in_ready;

  sdc_hold #(.SYM_W(SYM_W), .IN_SYMS(IN_SYMS), .IDX_W(IDX_W), .EMP_W(EMP_W)) u_hold (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .full(full), .idx(idx), .last(last),
    .hold_data(hold_data), .hold_sop(hold_sop), .hold_eop(hold_eop)
  );

  sdc_pick #(.SYM_W(SYM_W), .IN_SYMS(IN_SYMS), .IDX_W(IDX_W)) u_pick (
    .hold_data(hold_data), .hold_sop(hold_sop), .hold_eop(hold_eop),
    .idx(idx), .last(last),
    .sym(out_data), .sym_sop(out_sop), .sym_eop(out_eop)
  );

  assign out_valid = full;
  assign out_empty = 1'b0;

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_sop) && $stable(out_eop)));

  // R2
  load_shows_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R7
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R4
  eop_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eop) |-> in_ready);

  // R3
  sop_once_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_ready) |=> !out_sop);

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/test_sym_narrow.sv
module test_sym_narrow;
  localparam int CLK_PER = 10;
  localparam int HALF    = CLK_PER / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0, in_ready;
  logic [191:0] in_data = '0;
  logic         in_sop = 1'b0, in_eop = 1'b0;
  logic [1:0]   in_empty = '0;
  logic         out_valid, out_ready = 1'b0;
  logic [63:0]  out_data;
  logic         out_sop, out_eop;
  logic [0:0]   out_empty;

  int total = 0, bad = 0, cyc = 0, n_got = 0;
  bit done = 0;
  logic [63:0] got_d   [64];
  logic        got_sop [64];
  logic        got_eop [64];
  int          got_cyc [64];

  sym_narrow i_sym_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty)
  );

  always #(HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: records narrow transfers just before the rising edge
  always @(negedge clk) begin
    #(HALF - 1);
    if (!rst && out_valid && out_ready && n_got < 64) begin
      got_d[n_got]   = out_data;
      got_sop[n_got] = out_sop;
      got_eop[n_got] = out_eop;
      got_cyc[n_got] = cyc;
      n_got++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [191:0] d, input bit s, input bit e,
                      input logic [1:0] emp);
    bit hs;
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e; in_empty = emp;
    do begin
      #(HALF - 1);
      hs = in_ready;
      @(negedge clk);
    end while (!hs);
  endtask

  task automatic idle();
    in_valid = 1'b0; in_data = {3{64'hDEAD_BEEF_0BAD_F00D}}; in_sop = 1'b1;
    in_eop = 1'b1; in_empty = 2'd0;
  endtask

  task automatic wait_got(input int n);
    for (int i = 0; i < 40 && n_got < n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    n_got = 0;
  endtask

  task automatic t_reset();
    do_reset();
    #(HALF - 1);
    check(out_valid == 1'b0, "R9 out_valid after reset", 64'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after reset", 64'(in_ready), 1);
    @(negedge clk);
    idle();
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #(HALF - 1);
    check(out_valid == 1'b0 && n_got == 0, "R2 no load without in_valid",
          64'(n_got), 0);
    check(out_empty == 1'b0, "R10 out_empty", 64'(out_empty), 0);
    @(negedge clk);
  endtask

  task automatic t_single();
    n_got = 0; out_ready = 1'b1;
    send({64'hA1, 64'hB2, 64'hC3}, 1, 1, 2'd0);
    idle(); wait_got(3);
    check(n_got == 3, "R4 E=0 count", 64'(n_got), 3);
    check(got_d[0] == 64'hA1 && got_d[1] == 64'hB2 && got_d[2] == 64'hC3,
          "R1 symbol order", got_d[0], 64'hA1);
    check(got_sop[0] && !got_sop[1] && !got_sop[2], "R3 sop placement",
          {61'd0, got_sop[0], got_sop[1], got_sop[2]}, 3'b100);
    check(!got_eop[0] && !got_eop[1] && got_eop[2], "R4 eop placement",
          {61'd0, got_eop[0], got_eop[1], got_eop[2]}, 3'b001);
  endtask

  task automatic t_stream_e1();
    bit gap = 0;
    n_got = 0; out_ready = 1'b1;
    send({64'h11, 64'h12, 64'h13}, 1, 0, 2'd0);
    send({64'h21, 64'h22, 64'h23}, 0, 1, 2'd1);
    idle(); wait_got(5);
    check(n_got == 5, "R4 E=1 count", 64'(n_got), 5);
    check(got_d[3] == 64'h21 && got_d[4] == 64'h22, "R1 second beat order",
          got_d[4], 64'h22);
    check(got_eop[4] && !got_eop[2] && !got_eop[3], "R4 eop on kept symbol",
          64'(got_eop[4]), 1);
    check(!got_sop[3], "R3 no sop on later beat", 64'(got_sop[3]), 0);
    for (int i = 0; i < 4; i++) if (got_cyc[i+1] != got_cyc[i] + 1) gap = 1;
    check(!gap, "R7 back-to-back without bubble", 64'(gap), 0);
  endtask

  task automatic t_e2_e3();
    n_got = 0; out_ready = 1'b1;
    send({64'h31, 64'h32, 64'h33}, 1, 1, 2'd2);
    idle(); wait_got(1);
    check(n_got == 1 && got_d[0] == 64'h31, "R4 E=2 one symbol",
          64'(n_got), 1);
    check(got_sop[0] && got_eop[0], "R4 E=2 sop and eop together",
          {62'd0, got_sop[0], got_eop[0]}, 2'b11);
    n_got = 0;
    send({64'h41, 64'h42, 64'h43}, 1, 1, 2'd3);
    idle(); wait_got(1);
    check(n_got == 1 && got_d[0] == 64'h41 && got_eop[0], "R6 E=3 as 2",
          64'(n_got), 1);
  endtask

  task automatic t_empty_ignored();
    n_got = 0; out_ready = 1'b1;
    send({64'h51, 64'h52, 64'h53}, 1, 0, 2'd2);
    idle(); wait_got(3);
    check(n_got == 3 && got_d[2] == 64'h53, "R5 empty ignored without eop",
          64'(n_got), 3);
    check(!got_eop[0] && !got_eop[1] && !got_eop[2], "R5 no eop",
          {61'd0, got_eop[0], got_eop[1], got_eop[2]}, 0);
  endtask

  task automatic t_backpressure();
    bit hold_ok = 1;
    n_got = 0; out_ready = 1'b0;
    send({64'h61, 64'h62, 64'h63}, 1, 1, 2'd0);
    in_data = {64'h71, 64'h72, 64'h73};
    for (int i = 0; i < 4; i++) begin
      #(HALF - 1);
      if (!(out_valid && out_data == 64'h61 && out_sop && !out_eop)) hold_ok = 0;
      @(negedge clk);
    end
    check(hold_ok, "R8 output held under backpressure", out_data, 64'h61);
    #(HALF - 1);
    check(!in_ready, "R7 in_ready low while full", 64'(in_ready), 0);
    check(n_got == 0, "R2 no transfer without out_ready", 64'(n_got), 0);
    @(negedge clk);
    idle();
    out_ready = 1'b1;
    wait_got(3);
    check(n_got == 3 && got_d[1] == 64'h62 && got_d[2] == 64'h63,
          "R1 order after stall", got_d[2], 64'h63);
  endtask

  task automatic t_reset_mid();
    out_ready = 1'b0;
    send({64'h81, 64'h82, 64'h83}, 1, 1, 2'd0);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #(HALF - 1);
    check(!out_valid && in_ready, "R9 reset clears held beat",
          64'(out_valid), 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    t_reset();
    t_single();
    t_stream_e1();
    t_e2_e3();
    t_empty_ignored();
    t_backpressure();
    t_reset_mid();
    summary();
  end

endmodule